// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

A single-clock synchronous static memory with two 9-bit byte lanes and a built-in two-bit burst address counter. Every control input, the address and the write data are captured on the rising clock edge. Two transfer-start inputs begin a new burst, and they follow different rules. The processor-side start always reads, and it wins when both starts are low. The controller-side start reads or writes depending on the byte-lane write enables. Chip enable is looked at only on a cycle that loads a new base address. When it is high on such a cycle, the device stays deselected until a later start finds it low.

Between starts, the burst-advance input picks one of two actions. It can step the two low address bits, modulo 4, from the loaded starting value while the upper bits stay fixed. Or it can hold the address, which inserts a wait state. Reads show the word at the registered address during the cycle that follows the capturing edge. The asynchronous output enable only gates a separate drive-enable output; the block has no tri-state pin. The array depth is a parameter: the default gives 2K words, and an address width of 15 gives 32K words.

Top module: `burst_sram`

## Requirements
- R1: After synchronous reset the block is deselected and `drive_en` stays 0. Continue and suspend cycles issued before any start remain idle and do not drive.
- R2: A cycle with `proc_start_n`=0 and `chip_en_n`=0 loads `addr` and performs a read, whatever `ctrl_start_n`, `lo_wr_n` and `hi_wr_n` are. No word is written.
- R3: A cycle with `ctrl_start_n`=0, `proc_start_n`=1 and `chip_en_n`=0 loads `addr`. It writes if `lo_wr_n` or `hi_wr_n` is 0, and reads otherwise.
- R4: Chip enable is sampled only when a start input is low. A start with `chip_en_n`=1 deselects the device. While deselected, continue and suspend cycles neither write nor drive. `chip_en_n` is ignored on continue cycles.
- R5: With both starts high and `burst_adv_n`=0, address bits [1:0] step +1 modulo 4 before the access, and the upper bits stay at the loaded value. Four steps return the address to the starting word.
- R6: With both starts high and `burst_adv_n`=1, the access repeats the current address.
- R7: `lo_wr_n`=0 writes data bits [8:0] and `hi_wr_n`=0 writes data bits [17:9]. A lane whose enable is 1 keeps its old contents.
- R8: A processor start followed by a cycle with both starts high, `burst_adv_n`=1 and a lane enable low writes that cycle's data to the address loaded by the start.
- R9: `drive_en` is 1 only during a read access while `out_en_n`=0. It follows `out_en_n` with no clock. It is 0 during write and deselected accesses.
- R10: The word at the access address appears on `rdata` right after the capturing edge. A write is visible to a read issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | External word address, used on start cycles |
| wdata | input | 2*LANE_W | Write data, lower lane in the low bits |
| chip_en_n | input | 1 | Active-low chip enable, sampled on start cycles |
| proc_start_n | input | 1 | Active-low processor-side transfer start (read only, highest priority) |
| ctrl_start_n | input | 1 | Active-low controller-side transfer start (read or write) |
| burst_adv_n | input | 1 | Active-low burst advance; high inserts a wait state |
| lo_wr_n | input | 1 | Active-low lower-lane write enable |
| hi_wr_n | input | 1 | Active-low upper-lane write enable |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | 2*LANE_W | Word at the current access address |
| drive_en | output | 1 | High when `rdata` is to be driven onto the bus |

## Verification
All results are due one clock after the inputs are applied. The access address, the access kind and any write all take effect at the edge that captures the inputs. The bench drives inputs on the falling edge and samples shortly after the next rising edge, so a read shows the addressed word in that window, and a write shows up in the read issued in the following cycle. `drive_en` is the one exception. Its response to `out_en_n` is checked a few time units after the pin moves, with no clock edge in between.

// File: rtl/burst_sram_pkg.sv
// Shared types for the burst SRAM.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package burst_sram_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;
endpackage

// File: rtl/burst_addr_gen.sv
// Burst address generator: holds the access address. It loads a base, steps
// the low BURST_W bits with wrap while keeping the upper bits, or holds.
// Assumes: load and advance are never both meaningful; load has priority.
module burst_addr_gen #(
    parameter int ADDR_W  = 11,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr
);
    localparam int HI_W = ADDR_W - BURST_W;

    logic [BURST_W-1:0] low_step;

    // Wrapping increment of the burst bits only.
    assign low_step = cur_addr[BURST_W-1:0] + BURST_W'(1);

    // Choose the address of the coming access.
    always_comb begin
        if (load)
            nxt_addr = base;
        else if (advance)
            nxt_addr = {cur_addr[ADDR_W-1 -: HI_W], low_step};
        else
            nxt_addr = cur_addr;
    end

    // Hold the access address; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_addr <= '0;
        else
            cur_addr <= nxt_addr;
    end
endmodule

// File: rtl/burst_ctrl.sv
// Burst control: decodes start / continue / suspend from the sampled inputs,
// keeps the latched selection flag and the registered access kind, and
// issues the write strobe for the array at the capturing edge.
// Assumes: inputs are stable around the rising edge of clk.
module burst_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              p_start_n,
    input  logic              c_start_n,
    input  logic              adv_n,
    input  logic [LANES-1:0]  lane_wr_n,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LANES-1:0]  lane_wr,
    output logic [ADDR_W-1:0] acc_addr,
    output acc_e              acc_op,
    output logic              selected
);
    logic any_start, any_wr, load, advance, sel_d;
    acc_e op_d;
    logic [ADDR_W-1:0] nxt_addr;

    assign any_start = !p_start_n || !c_start_n;
    assign any_wr    = !(&lane_wr_n);

    // Decode the operation of this cycle.
    always_comb begin
        load    = 1'b0;
        advance = 1'b0;
        sel_d   = selected;
        op_d    = ACC_IDLE;
        if (any_start) begin
            if (ce_n) begin
                sel_d = 1'b0;
            end else begin
                sel_d = 1'b1;
                load  = 1'b1;
                op_d  = (!p_start_n || !any_wr) ? ACC_READ : ACC_WRITE;
            end
        end else if (selected) begin
            advance = !adv_n;
            op_d    = any_wr ? ACC_WRITE : ACC_READ;
        end
    end

    burst_addr_gen #(.ADDR_W(ADDR_W), .BURST_W(2)) u_agen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .advance  (advance),
        .base     (addr),
        .cur_addr (acc_addr),
        .nxt_addr (nxt_addr)
    );

    // Write request for the array, taken at this edge.
    assign wr_en   = (op_d == ACC_WRITE);
    assign wr_addr = nxt_addr;
    assign lane_wr = ~lane_wr_n;

    // Register the selection flag and the access kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            selected <= 1'b0;
            acc_op   <= ACC_IDLE;
        end else begin
            selected <= sel_d;
            acc_op   <= op_d;
        end
    end
endmodule

// File: rtl/sram_lanes.sv
// Lane-split storage: one memory per byte lane, each written on its own
// strobe, all read asynchronously at one address.
// Assumes: contents are undefined until written; no reset of the array.
module sram_lanes #(
    parameter int ADDR_W = 11,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        lane_wr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Store this lane when its strobe is set.
        always_ff @(posedge clk) begin
            if (wr_en && lane_wr[g])
                mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        // Present this lane at the access address.
        assign rdata[g*LANE_W +: LANE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/burst_sram.sv
// Synchronous burst SRAM top: two byte lanes, a wrapping two-bit burst counter,
// two transfer-start inputs and an asynchronous output enable that gates
// only the drive-enable output.
// Assumes: the bus outside turns rdata/drive_en into a tri-state pin.
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int LANE_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*LANE_W-1:0]   wdata,
    input  logic                  chip_en_n,
    input  logic                  proc_start_n,
    input  logic                  ctrl_start_n,
    input  logic                  burst_adv_n,
    input  logic                  lo_wr_n,
    input  logic                  hi_wr_n,
    input  logic                  out_en_n,
    output logic [2*LANE_W-1:0]   rdata,
    output logic                  drive_en
);
    localparam int LANES = 2;

    logic              wr_en, selected;
    logic [ADDR_W-1:0] wr_addr, acc_addr;
    logic [LANES-1:0]  lane_wr;
    acc_e              acc_op;

    burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .ce_n      (chip_en_n),
        .p_start_n (proc_start_n),
        .c_start_n (ctrl_start_n),
        .adv_n     (burst_adv_n),
        .lane_wr_n ({hi_wr_n, lo_wr_n}),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .lane_wr   (lane_wr),
        .acc_addr  (acc_addr),
        .acc_op    (acc_op),
        .selected  (selected)
    );

    sram_lanes #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .lane_wr (lane_wr),
        .wdata   (wdata),
        .rd_addr (acc_addr),
        .rdata   (rdata)
    );

    // Drive only on a read access with the output enable low.
    assign drive_en = (acc_op == ACC_READ) && !out_en_n;
endmodule

// File: rtl/burst_sram_chk.sv
// Checker for burst_sram: temporal properties between the sampled inputs and
// the registered access state and outputs. Attached with bind below.
// Assumes: synchronous active-low reset on rst_n.
module burst_sram_chk
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              chip_en_n,
    input logic              proc_start_n,
    input logic              ctrl_start_n,
    input logic              burst_adv_n,
    input logic              lo_wr_n,
    input logic              hi_wr_n,
    input logic              drive_en,
    input logic [ADDR_W-1:0] acc_addr,
    input acc_e              acc_op,
    input logic              selected
);
    assert_proc_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_start_n && !chip_en_n) |=> (acc_op == ACC_READ && acc_addr == $past(addr)));

    assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_start_n && !ctrl_start_n && !chip_en_n && !(lo_wr_n && hi_wr_n))
        |=> (acc_op == ACC_WRITE && acc_addr == $past(addr)));

    assert_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(proc_start_n && ctrl_start_n) && chip_en_n) |=> (acc_op == ACC_IDLE && !drive_en));

    assert_advance_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_start_n && ctrl_start_n && !burst_adv_n && selected)
        |=> (acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1
             && acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])));

    assert_suspend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_start_n && ctrl_start_n && burst_adv_n) |=> $stable(acc_addr));

    assert_no_drive_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_start_n && ctrl_start_n && !(lo_wr_n && hi_wr_n)) |=> !drive_en);
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .chip_en_n    (chip_en_n),
    .proc_start_n (proc_start_n),
    .ctrl_start_n (ctrl_start_n),
    .burst_adv_n  (burst_adv_n),
    .lo_wr_n      (lo_wr_n),
    .hi_wr_n      (hi_wr_n),
    .drive_en     (drive_en),
    .acc_addr     (acc_addr),
    .acc_op       (acc_op),
    .selected     (selected)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int LW = 9;
    localparam int DW = 2 * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          chip_en_n = 1'b0;
    logic          proc_start_n = 1'b1;
    logic          ctrl_start_n = 1'b1;
    logic          burst_adv_n = 1'b1;
    logic          lo_wr_n = 1'b1;
    logic          hi_wr_n = 1'b1;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] rdata;
    logic          drive_en;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    logic [DW-1:0] model [0:(1<<AW)-1];

    burst_sram #(.ADDR_W(AW), .LANE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .chip_en_n(chip_en_n), .proc_start_n(proc_start_n),
        .ctrl_start_n(ctrl_start_n), .burst_adv_n(burst_adv_n),
        .lo_wr_n(lo_wr_n), .hi_wr_n(hi_wr_n), .out_en_n(out_en_n),
        .rdata(rdata), .drive_en(drive_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'((a * 613 + salt * 1999 + 77) ^ 18'h15A5A);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: inputs at the falling edge, return just after the rising edge.
    task automatic cyc(input logic ps, input logic cs, input logic av, input logic ce,
                       input logic lw, input logic uw, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        proc_start_n = ps; ctrl_start_n = cs; burst_adv_n = av; chip_en_n = ce;
        lo_wr_n = lw; hi_wr_n = uw; addr = a; wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_read(input logic [AW-1:0] a, input string req);
        chk(drive_en === 1'b1, {req, " drive"}, 32'(drive_en), 32'd1);
        chk(rdata === model[a], {req, " data"}, 32'(rdata), 32'(model[a]));
    endtask

    logic [AW-1:0] bases [3];

    initial begin
        bases[0] = 11'h000; bases[1] = 11'h7FC; bases[2] = 11'h2A8;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        cyc(1, 1, 1, 0, 1, 1, 11'h005, '0);
        chk(drive_en === 1'b0, "R1 idle after reset", 32'(drive_en), 32'd0);
        cyc(1, 1, 0, 0, 1, 1, 11'h006, '0);
        chk(drive_en === 1'b0, "R1 continue before start", 32'(drive_en), 32'd0);

        // R5/R6/R10/R4: burst write then burst read, every start offset
        for (int bi = 0; bi < 3; bi++) begin
            for (int s = 0; s < 4; s++) begin
                logic [AW-1:0] b0, ak;
                int salt;
                salt = bi * 4 + s;
                b0 = bases[bi] | AW'(s);
                model[b0] = pat(int'(b0), salt);
                cyc(1, 0, 1, 0, 0, 0, b0, model[b0]);
                chk(drive_en === 1'b0, "R9 no drive on write", 32'(drive_en), 32'd0);
                for (int k = 1; k < 4; k++) begin
                    ak = bases[bi] | AW'((s + k) & 3);
                    model[ak] = pat(int'(ak), salt);
                    // chip enable high and a stray address on continue: ignored (R4)
                    cyc(1, 1, 0, 1, 0, 0, ~b0, model[ak]);
                end
                // R2: processor start reads even with a lane enable low
                cyc(0, 1, 1, 0, 0, 1, b0, 18'h3FFFF);
                chk_read(b0, "R2/R10 burst first");
                ak = bases[bi] | AW'((s + 1) & 3);
                cyc(1, 1, 0, 0, 1, 1, ~b0, '0);
                chk_read(ak, "R5 step1");
                cyc(1, 1, 1, 0, 1, 1, ~b0, '0);
                chk_read(ak, "R6 suspend holds");
                for (int k = 2; k <= 4; k++) begin
                    ak = bases[bi] | AW'((s + k) & 3);
                    cyc(1, 1, 0, 0, 1, 1, ~b0, '0);
                    chk_read(ak, (k == 4) ? "R5 wrap to start" : "R5 step");
                end
            end
        end

        // R7: lane writes
        model[11'h155] = pat(11'h155, 50);
        cyc(1, 0, 1, 0, 0, 0, 11'h155, model[11'h155]);
        cyc(1, 0, 1, 0, 0, 1, 11'h155, 18'h3FFFF);
        model[11'h155][8:0] = 9'h1FF;
        cyc(0, 1, 1, 0, 1, 1, 11'h155, '0);
        chk_read(11'h155, "R7 lower lane only");
        cyc(1, 0, 1, 0, 1, 0, 11'h155, 18'h00000);
        model[11'h155][17:9] = 9'h000;
        cyc(0, 1, 1, 0, 1, 1, 11'h155, '0);
        chk_read(11'h155, "R7 upper lane only");

        // R2: both starts low with lanes enabled -> read, no write
        cyc(0, 0, 1, 0, 0, 0, 11'h155, 18'h0ABCD);
        chk_read(11'h155, "R2 proc start wins");
        cyc(0, 1, 1, 0, 1, 1, 11'h155, '0);
        chk_read(11'h155, "R2 nothing written");

        // R3: controller start without lane enable reads
        cyc(1, 0, 1, 0, 1, 1, 11'h7FD, 18'h11111);
        chk_read(11'h7FD, "R3 ctrl start read");

        // R8: two-cycle single write
        model[11'h0F3] = 18'h2C3A1;
        cyc(0, 1, 1, 0, 1, 1, 11'h0F3, '0);
        cyc(1, 1, 1, 0, 0, 0, 11'h444, model[11'h0F3]);
        chk(drive_en === 1'b0, "R8 write cycle no drive", 32'(drive_en), 32'd0);
        cyc(0, 1, 1, 0, 1, 1, 11'h0F3, '0);
        chk_read(11'h0F3, "R8 single write landed");

        // R4: start with chip enable high deselects; continue writes dropped
        cyc(1, 0, 1, 1, 0, 0, 11'h7FD, 18'h00001);
        chk(drive_en === 1'b0, "R4 deselected start", 32'(drive_en), 32'd0);
        cyc(1, 1, 0, 0, 0, 0, 11'h7FD, 18'h00002);
        chk(drive_en === 1'b0, "R4 deselected continue", 32'(drive_en), 32'd0);
        cyc(1, 1, 1, 0, 1, 1, 11'h7FD, '0);
        chk(drive_en === 1'b0, "R4 deselected suspend", 32'(drive_en), 32'd0);
        cyc(0, 1, 1, 0, 1, 1, 11'h7FD, '0);
        chk_read(11'h7FD, "R4 reselect, nothing written");
        cyc(1, 1, 0, 0, 1, 1, 11'h000, '0);
        chk_read(11'h7FE, "R4 wrap after reselect");

        // R9: asynchronous output enable
        @(negedge clk); out_en_n = 1'b1;
        cyc(0, 1, 1, 0, 1, 1, 11'h0F3, '0);
        chk(drive_en === 1'b0, "R9 oe high", 32'(drive_en), 32'd0);
        out_en_n = 1'b0;
        #1;
        chk(drive_en === 1'b1, "R9 oe low no clock", 32'(drive_en), 32'd1);
        chk(rdata === model[11'h0F3], "R9 data", 32'(rdata), 32'(model[11'h0F3]));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule